// File: doc/BRIEF.md
# Time-Multiplexed Space Switch with Per-Output Slot Control

This block is a digital space array for a transit switching stage. It has `NUM_LINES` incoming and `NUM_LINES` outgoing trunks. Each trunk carries `NUM_SLOTS` time slots per frame, and one clock cycle is one time slot. Every outgoing trunk owns a small control store with one word per time slot. That word names the incoming trunk whose sample should appear on the outgoing trunk in that slot, or it marks the slot as unconnected. A shared slot counter addresses all the control stores at once, so all outgoing samples of a slot are switched together in that slot's cycle.

Several control words may name the same incoming trunk. Because of this, one source can feed many outputs, or every output (broadcast), in the same slot. Connection changes are written one word at a time into a shadow copy of the control stores. The shadow copy is transferred to the working copy as a whole at a frame boundary, so a running frame always uses one consistent connection map.

Top module: `tdmSpaceSwitch`

## Requirements
- R1: While `rstN` is low, and until the first control write has been committed, every output lane carries the idle pattern 0xFF, `slotNum` is 0, and every control word reads as unconnected.
- R2: `slotNum` advances by one on each clock and returns from `NUM_SLOTS-1` to 0.
- R3: When `frameSync` is high at a clock edge, `slotNum` is 0 after that edge, whatever its previous value.
- R4: For outgoing lane j, the value seen in the cycle after slot s equals the incoming lane sample present during slot s on the trunk named by the committed control word (j, s). This is one clock of latency.
- R5: When the same incoming trunk is named by the control words of several or all lanes for a slot, all of those lanes carry that trunk's sample.
- R6: A control word whose connect flag (`cfgValid`) is 0 makes its lane output 0xFF for that slot.
- R7: A write updates only the shadow word (`cfgLine`, `cfgSlot`). All shadow words become active together at the frame-boundary edge, which is the edge after which `slotNum` is 0 (wrap or sync). A write presented in the same cycle as that edge is committed at the following boundary.
- R8: The words of one lane are independent per slot, so a lane can take a different source in every slot of a frame.
- R9: Lane k of `inData` and of `outData` occupies bits [k*SAMPLE_W +: SAMPLE_W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one time slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Forces the next slot to 0 and marks a frame boundary |
| inData | input | NUM_LINES*SAMPLE_W | Incoming trunk samples of the current slot, packed by lane |
| cfgWrEn | input | 1 | Write strobe for one shadow control word |
| cfgLine | input | $clog2(NUM_LINES) | Outgoing lane of the word to write |
| cfgSlot | input | $clog2(NUM_SLOTS) | Time slot of the word to write |
| cfgValid | input | 1 | 1 connects the lane in that slot, 0 leaves it idle |
| cfgInlet | input | $clog2(NUM_LINES) | Incoming trunk selected by the word |
| outData | output | NUM_LINES*SAMPLE_W | Switched samples, registered, packed by lane |
| slotNum | output | $clog2(NUM_SLOTS) | Current time slot number |

## Verification
The hardest case to reach is the commit race, where a control write falls in the last slot of a frame, on the very edge that moves the shadow map into service. The same race occurs when `frameSync` cuts a frame short in the middle. The stimulus waits on the reference model's slot count so that it can place writes and sync pulses on exact slots: the final slot, a mid-frame slot, and a slot just after a forced restart. The bench then compares every lane on every clock for at least two following frames, which shows when each change actually took effect.

// File: rtl/tsw_pkg.sv
`timescale 1ns/1ps
package tsw_pkg;
  // Strobes passed from the slot controller to the datapath.
  typedef struct packed {
    logic commit;   // this edge is a frame boundary: shadow map goes live
  } tswStrobe_t;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/tswCtrl.sv
`timescale 1ns/1ps
module tswCtrl
  import tsw_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  output logic [SLOT_W-1:0] slotCnt,
  output tswStrobe_t        strobe
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic lastSlot;
  assign lastSlot      = (slotCnt == LAST_SLOT);
  assign strobe.commit = frameSync | lastSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              slotCnt <= '0;
    else if (strobe.commit) slotCnt <= '0;
    else                    slotCnt <= slotCnt + SLOT_W'(1);
  end

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(slotCnt) < NUM_SLOTS);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSync && !lastSlot) |=> (slotCnt == $past(slotCnt) + SLOT_W'(1)));

  // R3
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (slotCnt == '0));
endmodule

// File: rtl/tswDatapath.sv
`timescale 1ns/1ps
module tswDatapath
  import tsw_pkg::*;
#(
  parameter int         NUM_LINES = 4,
  parameter int         NUM_SLOTS = 8,
  parameter int         SAMPLE_W  = 8,
  parameter int         LINE_W    = $clog2(NUM_LINES),
  parameter int         SLOT_W    = $clog2(NUM_SLOTS),
  parameter logic [SAMPLE_W-1:0] IDLE = SAMPLE_W'(IDLE_BYTE)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  tswStrobe_t                    strobe,
  input  logic [SLOT_W-1:0]             slot,
  input  logic [NUM_LINES*SAMPLE_W-1:0] inData,
  input  logic                          cfgWrEn,
  input  logic [LINE_W-1:0]             cfgLine,
  input  logic [SLOT_W-1:0]             cfgSlot,
  input  logic                          cfgValid,
  input  logic [LINE_W-1:0]             cfgInlet,
  output logic [NUM_LINES*SAMPLE_W-1:0] outData
);
  localparam int CW = LINE_W + 1;   // {connect flag, inlet}

  logic [NUM_LINES-1:0][NUM_SLOTS-1:0][CW-1:0] shadowMem;
  logic [NUM_LINES-1:0][NUM_SLOTS-1:0][CW-1:0] activeMem;
  logic [NUM_LINES-1:0][SAMPLE_W-1:0]          inLanes;
  logic [NUM_LINES-1:0][SAMPLE_W-1:0]          outLanes;

  assign inLanes = inData;
  assign outData = outLanes;

  // Shadow store: single-word updates from the write port.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowMem <= '0;
    end else if (cfgWrEn && int'(cfgLine) < NUM_LINES && int'(cfgSlot) < NUM_SLOTS) begin
      shadowMem[cfgLine][cfgSlot] <= {cfgValid, cfgInlet};
    end
  end

  // Active store: whole-map copy at a frame boundary only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              activeMem <= '0;
    else if (strobe.commit) activeMem <= shadowMem;
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLane
    logic [CW-1:0]     word;
    logic [LINE_W-1:0] sel;
    logic              connected;

    assign word      = activeMem[g][slot];
    assign sel       = word[LINE_W-1:0];
    assign connected = word[CW-1] && (int'(sel) < NUM_LINES);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          outLanes[g] <= IDLE;
      else if (connected) outLanes[g] <= inLanes[sel];
      else                outLanes[g] <= IDLE;
    end

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
      !activeMem[g][slot][CW-1] |=> (outLanes[g] == IDLE));

    // R4
    route_chk: assert property (@(posedge clk) disable iff (!rstN)
      activeMem[g][slot][CW-1] |=>
        (outLanes[g] == $past(inLanes[activeMem[g][slot][LINE_W-1:0]])));
  end

  // R7
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeMem));
endmodule

// File: rtl/tdmSpaceSwitch.sv
`timescale 1ns/1ps
module tdmSpaceSwitch
  import tsw_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_SLOTS = 8,
  parameter int SAMPLE_W  = 8,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameSync,
  input  logic [NUM_LINES*SAMPLE_W-1:0] inData,
  input  logic                          cfgWrEn,
  input  logic [LINE_W-1:0]             cfgLine,
  input  logic [SLOT_W-1:0]             cfgSlot,
  input  logic                          cfgValid,
  input  logic [LINE_W-1:0]             cfgInlet,
  output logic [NUM_LINES*SAMPLE_W-1:0] outData,
  output logic [SLOT_W-1:0]             slotNum
);
  tswStrobe_t        strobe;
  logic [SLOT_W-1:0] slotCnt;

  tswCtrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .slotCnt(slotCnt), .strobe(strobe)
  );

  tswDatapath #(
    .NUM_LINES(NUM_LINES), .NUM_SLOTS(NUM_SLOTS), .SAMPLE_W(SAMPLE_W),
    .LINE_W(LINE_W), .SLOT_W(SLOT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slot(slotCnt),
    .inData(inData), .cfgWrEn(cfgWrEn), .cfgLine(cfgLine),
    .cfgSlot(cfgSlot), .cfgValid(cfgValid), .cfgInlet(cfgInlet),
    .outData(outData)
  );

  assign slotNum = slotCnt;
endmodule

// File: tb/tdmSpaceSwitch_tb.sv
`timescale 1ns/1ps
module tdmSpaceSwitch_tb;
  localparam int N  = 4;
  localparam int M  = 8;
  localparam int W  = 8;
  localparam int LW = $clog2(N);
  localparam int SW = $clog2(M);

  logic            clk = 1'b0;
  logic            rstN;
  logic            frameSync;
  logic [N*W-1:0]  inData;
  logic            cfgWrEn;
  logic [LW-1:0]   cfgLine;
  logic [SW-1:0]   cfgSlot;
  logic            cfgValid;
  logic [LW-1:0]   cfgInlet;
  logic [N*W-1:0]  outData;
  logic [SW-1:0]   slotNum;

  tdmSpaceSwitch #(.NUM_LINES(N), .NUM_SLOTS(M), .SAMPLE_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .inData(inData),
    .cfgWrEn(cfgWrEn), .cfgLine(cfgLine), .cfgSlot(cfgSlot),
    .cfgValid(cfgValid), .cfgInlet(cfgInlet), .outData(outData),
    .slotNum(slotNum)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  int    total = 0;
  int    bad   = 0;
  bit    finished = 0;
  string curReq = "R1";

  // Behavioural reference model
  bit         shV [N][M];
  int         shI [N][M];
  bit         acV [N][M];
  int         acI [N][M];
  int         mSlot;
  logic [W-1:0] expOut [N];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < N; j++) begin
        expOut[j] = 8'hFF;
        for (int s = 0; s < M; s++) begin
          shV[j][s] = 0; shI[j][s] = 0; acV[j][s] = 0; acI[j][s] = 0;
        end
      end
      mSlot = 0;
    end else begin
      bit boundary;
      for (int j = 0; j < N; j++)
        expOut[j] = acV[j][mSlot] ? inData[acI[j][mSlot]*W +: W] : 8'hFF;
      boundary = frameSync || (mSlot == M-1);
      if (boundary)
        for (int j = 0; j < N; j++)
          for (int s = 0; s < M; s++) begin
            acV[j][s] = shV[j][s]; acI[j][s] = shI[j][s];
          end
      if (cfgWrEn) begin
        shV[cfgLine][cfgSlot] = cfgValid;
        shI[cfgLine][cfgSlot] = int'(cfgInlet);
      end
      mSlot = boundary ? 0 : mSlot + 1;
    end
  end

  task automatic compareAll();
    total++;
    if (int'(slotNum) != mSlot) begin
      bad++;
      $display("FAIL %s slotNum actual=%0d expected=%0d", curReq, slotNum, mSlot);
    end
    for (int j = 0; j < N; j++) begin
      total++;
      if (outData[j*W +: W] !== expOut[j]) begin
        bad++;
        $display("FAIL %s lane %0d slot-prev out actual=%02h expected=%02h",
                 curReq, j, outData[j*W +: W], expOut[j]);
      end
    end
  endtask

  task automatic cyc(bit fs, bit wr, int line, int slot, bit v, int inl);
    @(negedge clk);
    compareAll();
    frameSync = fs;
    cfgWrEn   = wr;
    cfgLine   = LW'(line);
    cfgSlot   = SW'(slot);
    cfgValid  = v;
    cfgInlet  = LW'(inl);
    for (int k = 0; k < N; k++) inData[k*W +: W] = W'($urandom);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic waitSlot(int s);
    while (mSlot != s) cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rstN = 0; frameSync = 0; cfgWrEn = 0; cfgLine = '0; cfgSlot = '0;
    cfgValid = 0; cfgInlet = '0; inData = '0;
    repeat (3) @(negedge clk);
    curReq = "R1 reset state";
    compareAll();
    rstN = 1;

    curReq = "R1 R2 R6 free-running count, all words unconnected";
    idle(2*M + 3);

    // R7: mid-frame write must wait for the boundary
    waitSlot(2);
    curReq = "R7 mid-frame write deferred";
    cyc(0, 1, 1, 5, 1, 3);
    idle(2*M);

    // R8, R4, R9: a different source per lane and slot
    curReq = "R8 R4 R9 slot-varying routes";
    for (int j = 0; j < N; j++)
      for (int s = 0; s < M; s++) cyc(0, 1, j, s, 1, (j + s) % N);
    idle(2*M + 1);

    // R5: broadcast inlet 1 to every lane in slot 4
    curReq = "R5 broadcast";
    for (int j = 0; j < N; j++) cyc(0, 1, j, 4, 1, 1);
    idle(2*M + 1);

    // R3: sync pulses mid-frame and on the last slot
    curReq = "R3 frame sync";
    waitSlot(3);
    cyc(1, 0, 0, 0, 0, 0);
    idle(M + 2);
    waitSlot(M-1);
    cyc(1, 0, 0, 0, 0, 0);
    idle(3);
    waitSlot(1);
    cyc(1, 1, 3, 0, 1, 0);   // write on a sync-boundary edge
    idle(2*M + 1);

    // R6: disconnect lane 2 everywhere
    curReq = "R6 null words give idle";
    for (int s = 0; s < M; s++) cyc(0, 1, 2, s, 0, 0);
    idle(2*M + 1);

    // R7: write presented on the wrap edge lands one frame later
    curReq = "R7 write on boundary cycle";
    waitSlot(M-1);
    cyc(0, 1, 0, 0, 1, 2);
    idle(2*M + 2);

    @(negedge clk);
    compareAll();
    finishRun();
  end

  initial begin
    #(50000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end
endmodule